// File: doc/BRIEF.md
# Partitioned SIMD Vector ALU

This unit does lane-wise add, subtract and magnitude compare on two 64-bit words. For each operation the caller chooses how the word is split into lanes: eight lanes of 8 bits, four of 16 bits or two of 32 bits. Each lane is read as unsigned or as two's-complement signed. An add or subtract either wraps modulo the lane size or saturates to the lane range.

The datapath is one carry chain built from 8-bit segments. The chain is cut at every lane boundary that the current lane size selects. A lane-fixup stage then applies saturation or builds a compare mask for each lane width. The result for the selected width goes into an output register.

The block has no internal state machine. Its only sequential behaviour is the output register, which takes a new value on each edge where `in_valid` is high and holds its value otherwise.

Top module: `vsimd_alu`

## Requirements
- R1: While `rst_n` is low, and after reset until the first accepted operation, `out_valid` is 0 and `out_result` is all zeros.
- R2: The block responds one cycle after it accepts an operation. After each rising clock edge, `out_valid` equals the value `in_valid` had at that edge. The result of an operation accepted at one edge appears on `out_result` after that same edge.
- R3: When `in_valid` is low at an edge, `out_result` keeps its previous value, whatever the other inputs are.
- R4: `lane_sel` picks the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes, and 2'b10 or 2'b11 give 32-bit lanes. Lane j takes bits [j*W+W-1 : j*W]. No carry or borrow passes from one lane into the next.
- R5: `op_code` 2'b00 adds per lane. With `do_sat` low, the result is (a+b) mod 2^W.
- R6: `op_code` 2'b01 subtracts per lane (a−b). With `do_sat` low, the result is (a−b) mod 2^W.
- R7: With `do_sat` high and `is_signed` high, an add or subtract result is clamped into [−2^(W−1), 2^(W−1)−1].
- R8: With `do_sat` high and `is_signed` low, an add that overflows gives all ones. A subtract that underflows gives 0.
- R9: `op_code` 2'b10 tests a>b and 2'b11 tests a>=b, per lane. Each result lane is all ones when the test is true and all zeros when it is false. `is_signed` decides whether lanes are compared as signed or unsigned. `do_sat` has no effect on compares.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept the operation on this edge |
| op_a | input | 64 | First operand vector |
| op_b | input | 64 | Second operand vector |
| op_code | input | 2 | 00 add, 01 sub, 10 greater-than, 11 greater-or-equal |
| lane_sel | input | 2 | 00 8-bit, 01 16-bit, 10/11 32-bit lanes |
| is_signed | input | 1 | Lanes are two's-complement signed |
| do_sat | input | 1 | Saturate add/sub instead of wrapping |
| out_valid | output | 1 | Result register holds a fresh result |
| out_result | output | 64 | Registered result vector |

## Verification
Every result is due exactly one rising edge after `in_valid` is sampled high. `out_valid` follows `in_valid` with the same one-edge delay. The bench drives each operation just after a falling edge. At the next falling edge, half a period after the capturing edge, it compares both outputs with a behavioural per-lane model kept in integers. When `in_valid` is low, the model keeps its last prediction, so the same comparison on that cycle also checks that the held value is unchanged.

// File: rtl/vsimd_pkg.sv
package vsimd_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_CGT = 2'b10,
        OP_CGE = 2'b11
    } vop_e;

    typedef enum logic [1:0] {
        LW_8   = 2'b00,
        LW_16  = 2'b01,
        LW_32  = 2'b10,
        LW_32X = 2'b11
    } lanew_e;

endpackage

// File: rtl/vsimd_carry_split.sv
// Segmented ripple adder: one segment per SEG_W bits, carry chain broken
// at every segment that starts a lane of the selected width.
module vsimd_carry_split #(
    parameter int DATA_W = 64,
    parameter int SEG_W  = 8
) (
    input  logic [DATA_W-1:0]        a,
    input  logic [DATA_W-1:0]        b,
    input  logic [1:0]               lane_sel,
    input  logic                     sub,
    output logic [DATA_W-1:0]        sum,
    output logic [DATA_W/SEG_W-1:0]  seg_cout
);
    localparam int NSEG = DATA_W / SEG_W;

    logic [DATA_W-1:0] b_eff;
    logic [NSEG-1:0]   seg_start;
    logic [NSEG-1:0]   seg_cin;

    assign b_eff = sub ? ~b : b;

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        localparam bit AT_16 = (i % 2) == 0;
        localparam bit AT_32 = (i % 4) == 0;
        logic [SEG_W:0] part;

        always_comb begin
            unique case (lane_sel)
                2'b00:   seg_start[i] = 1'b1;
                2'b01:   seg_start[i] = AT_16;
                default: seg_start[i] = AT_32;
            endcase
        end

        if (i == 0) begin : g_first
            assign seg_cin[i] = sub;
        end else begin : g_rest
            assign seg_cin[i] = seg_start[i] ? sub : seg_cout[i-1];
        end

        assign part = {1'b0, a[i*SEG_W +: SEG_W]}
                    + {1'b0, b_eff[i*SEG_W +: SEG_W]}
                    + {{SEG_W{1'b0}}, seg_cin[i]};
        assign sum[i*SEG_W +: SEG_W] = part[SEG_W-1:0];
        assign seg_cout[i]           = part[SEG_W];
    end

endmodule

// File: rtl/vsimd_lane_fix.sv
// Per-lane post-processing for one lane width: saturation or compare mask.
module vsimd_lane_fix
    import vsimd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0]        sum,
    input  logic [DATA_W/LANE_W-1:0] lane_cout,
    input  logic [DATA_W/LANE_W-1:0] a_msb,
    input  logic [DATA_W/LANE_W-1:0] b_msb,
    input  vop_e                     op,
    input  logic                     sgn,
    input  logic                     sat,
    output logic [DATA_W-1:0]        res
);
    localparam int NLANE = DATA_W / LANE_W;
    localparam logic [LANE_W-1:0] S_MAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] S_MIN = {1'b1, {(LANE_W-1){1'b0}}};

    for (genvar j = 0; j < NLANE; j++) begin : g_lane
        logic [LANE_W-1:0] raw;
        logic s_ovf, u_ovf, ge, gt, hit;

        always_comb begin
            raw   = sum[j*LANE_W +: LANE_W];
            s_ovf = (a_msb[j] == b_msb[j]) && (raw[LANE_W-1] != a_msb[j]);
            u_ovf = (op == OP_ADD) ? lane_cout[j] : ~lane_cout[j];
            ge    = sgn ? ~(raw[LANE_W-1] ^ s_ovf) : lane_cout[j];
            gt    = ge && (raw != '0);
            hit   = (op == OP_CGT) ? gt : ge;

            unique case (op)
                OP_CGT, OP_CGE:
                    res[j*LANE_W +: LANE_W] = hit ? '1 : '0;
                default: begin
                    if (sat && sgn && s_ovf)
                        res[j*LANE_W +: LANE_W] = a_msb[j] ? S_MIN : S_MAX;
                    else if (sat && !sgn && u_ovf)
                        res[j*LANE_W +: LANE_W] = (op == OP_SUB) ? '0 : '1;
                    else
                        res[j*LANE_W +: LANE_W] = raw;
                end
            endcase
        end
    end

endmodule

// File: rtl/vsimd_alu.sv
module vsimd_alu
    import vsimd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SEG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [1:0]        op_code,
    input  logic [1:0]        lane_sel,
    input  logic              is_signed,
    input  logic              do_sat,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);
    localparam int NSEG  = DATA_W / SEG_W;
    localparam int NWIDE = 3;

    vop_e              op;
    logic              sub;
    logic [DATA_W-1:0] sum;
    logic [NSEG-1:0]   seg_cout;
    logic [DATA_W-1:0] res_w [NWIDE];
    logic [DATA_W-1:0] res_sel;

    assign op  = vop_e'(op_code);
    assign sub = (op != OP_ADD);

    vsimd_carry_split #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_add (
        .a        (op_a),
        .b        (op_b),
        .lane_sel (lane_sel),
        .sub      (sub),
        .sum      (sum),
        .seg_cout (seg_cout)
    );

    for (genvar k = 0; k < NWIDE; k++) begin : g_width
        localparam int LW  = SEG_W << k;
        localparam int NL  = DATA_W / LW;
        localparam int SPL = LW / SEG_W;
        logic [NL-1:0] l_cout, l_am, l_bm;

        for (genvar j = 0; j < NL; j++) begin : g_msb
            assign l_cout[j] = seg_cout[j*SPL + SPL - 1];
            assign l_am[j]   = op_a[j*LW + LW - 1];
            assign l_bm[j]   = op_b[j*LW + LW - 1] ^ sub;
        end

        vsimd_lane_fix #(.DATA_W(DATA_W), .LANE_W(LW)) u_fix (
            .sum       (sum),
            .lane_cout (l_cout),
            .a_msb     (l_am),
            .b_msb     (l_bm),
            .op        (op),
            .sgn       (is_signed),
            .sat       (do_sat),
            .res       (res_w[k])
        );
    end

    always_comb begin
        unique case (lanew_e'(lane_sel))
            LW_8:    res_sel = res_w[0];
            LW_16:   res_sel = res_w[1];
            default: res_sel = res_w[2];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_result <= res_sel;
        end
    end

endmodule

// File: rtl/vsimd_alu_chk.sv
module vsimd_alu_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic [1:0]        op_code,
    input logic [1:0]        lane_sel,
    input logic              is_signed,
    input logic              do_sat,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result
);
    localparam int NB = DATA_W / 8;

    function automatic bit bytes_masks(input logic [DATA_W-1:0] v);
        bit ok = 1'b1;
        for (int i = 0; i < NB; i++)
            if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic [DATA_W-1:0] byte_wrap_add(input logic [DATA_W-1:0] x,
                                                        input logic [DATA_W-1:0] y);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < NB; i++) r[i*8 +: 8] = x[i*8 +: 8] + y[i*8 +: 8];
        return r;
    endfunction

    function automatic bit bytes_not_below(input logic [DATA_W-1:0] r,
                                           input logic [DATA_W-1:0] x);
        bit ok = 1'b1;
        for (int i = 0; i < NB; i++)
            if (r[i*8 +: 8] < x[i*8 +: 8]) ok = 1'b0;
        return ok;
    endfunction

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));
    // R9
    cmp_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code[1]) |=> bytes_masks(out_result));
    // R5
    wrap_add8_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 2'b00 && !do_sat && lane_sel == 2'b00)
        |=> out_result == byte_wrap_add($past(op_a), $past(op_b)));
    // R8
    usat_add8_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 2'b00 && do_sat && !is_signed && lane_sel == 2'b00)
        |=> bytes_not_below(out_result, $past(op_a)));

endmodule

bind vsimd_alu vsimd_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_a       (op_a),
    .op_b       (op_b),
    .op_code    (op_code),
    .lane_sel   (lane_sel),
    .is_signed  (is_signed),
    .do_sat     (do_sat),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/vsimd_alu_test.sv
`timescale 1ns/1ps
module vsimd_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [1:0]  op_code = '0, lane_sel = '0;
    logic        is_signed = 1'b0, do_sat = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [63:0] pred = '0;

    always #10 clk = ~clk;

    vsimd_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .op_code(op_code), .lane_sel(lane_sel), .is_signed(is_signed),
        .do_sat(do_sat), .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic [1:0] op, input logic [1:0] ls,
                                          input bit sg, input bit sat);
        int w = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
        longint m = longint'(1) << w;
        logic [63:0] acc = '0;
        for (int j = 0; j < 64 / w; j++) begin
            longint ua = longint'(a >> (j * w)) & (m - 1);
            longint ub = longint'(b >> (j * w)) & (m - 1);
            longint x  = (sg && ((ua >> (w - 1)) & 1) != 0) ? ua - m : ua;
            longint y  = (sg && ((ub >> (w - 1)) & 1) != 0) ? ub - m : ub;
            longint lo = sg ? -(m / 2) : 0;
            longint hi = sg ? (m / 2 - 1) : (m - 1);
            longint r;
            case (op)
                2'd0: r = x + y;
                2'd1: r = x - y;
                2'd2: r = (x > y) ? m - 1 : 0;
                default: r = (x >= y) ? m - 1 : 0;
            endcase
            if (op < 2 && sat) begin
                if (r > hi) r = hi;
                if (r < lo) r = lo;
            end
            acc = acc | (64'(r & (m - 1)) << (j * w));
        end
        return acc;
    endfunction

    function automatic string tag_of(input logic [1:0] op, input bit sg, input bit sat);
        if (op[1]) return "R9";
        if (sat) return sg ? "R7" : "R8";
        return (op == 2'd0) ? "R5" : "R6";
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [63:0] a, input logic [63:0] b, input logic [1:0] op,
                        input logic [1:0] ls, input bit sg, input bit sat, input bit vld,
                        input string req);
        op_a = a; op_b = b; op_code = op; lane_sel = ls;
        is_signed = sg; do_sat = sat; in_valid = vld;
        if (vld) pred = model(a, b, op, ls, sg, sat);
        @(negedge clk);
        check("R2", 64'(out_valid), 64'(vld));
        check(req, out_result, pred);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 64'(out_valid), 64'd0);
        check("R1", out_result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", out_result, 64'd0);

        // R4: byte lane FF+01 must not carry into the next byte
        step(64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 2'd0, 2'd0, 0, 0, 1, "R4");
        // R4: the same operands in 16-bit lanes do carry within the lane
        step(64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 2'd0, 2'd1, 0, 0, 1, "R4");
        // R4: lane_sel 11 acts as 32-bit lanes
        step(64'h0000_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd0, 2'd3, 0, 0, 1, "R4");
        // R6: borrow must not cross into the next 16-bit lane
        step(64'h0001_0000_0001_0000, 64'h0000_0001_0000_0001, 2'd1, 2'd1, 0, 0, 1, "R6");
        // R7: signed saturation both ways, 8-bit lanes
        step(64'h7F80_7F80_7F80_7F80, 64'h0101_0101_0101_0101, 2'd0, 2'd0, 1, 1, 1, "R7");
        step(64'h0080_0080_0080_0080, 64'h8001_8001_8001_8001, 2'd1, 2'd0, 1, 1, 1, "R7");
        // R8: unsigned add to all ones, unsigned underflow to zero
        step(64'hFFFF_FFF0_FFFF_FFF0, 64'h0000_0020_0000_0020, 2'd0, 2'd2, 0, 1, 1, "R8");
        step(64'h0000_0001_0000_0005, 64'h0000_0002_0000_0003, 2'd1, 2'd2, 0, 1, 1, "R8");
        // R9: compares, signed and unsigned, saturate flag set to show it is ignored
        step(64'h80FF_0102_7F00_0505, 64'h7F01_0201_8000_0505, 2'd2, 2'd0, 1, 1, 1, "R9");
        step(64'h80FF_0102_7F00_0505, 64'h7F01_0201_8000_0505, 2'd3, 2'd0, 0, 1, 1, "R9");
        // R3: no capture while in_valid is low
        step(64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 2'd0, 2'd0, 0, 0, 0, "R3");
        step(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 2'd1, 1, 1, 0, "R3");

        for (int n = 0; n < 400; n++) begin
            logic [63:0] a = {$urandom, $urandom};
            logic [63:0] b = {$urandom, $urandom};
            logic [1:0]  op = 2'($urandom);
            logic [1:0]  ls = 2'($urandom);
            bit sg  = 1'($urandom);
            bit sat = 1'($urandom);
            bit vld = ($urandom % 5) != 0;
            if (n % 7 == 0) b = a;
            step(a, b, op, ls, sg, sat, vld, vld ? tag_of(op, sg, sat) : "R3");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule